// File: doc/BRIEF.md
# Pulse-Stepped Trim Counter with Level-Qualified Store

This block owns a small trim setting that is nudged one code at a time by step pulses and kept in a non-volatile register across power cycles. Three control inputs arrive from outside the clock domain: an up-step pulse, a down-step pulse and a program-level flag. A fourth input, the adjust enable, decides whether the setting may be touched at all. Every input passes through a synchronizer. Step pulses act on their rising edge. The store is modelled inside the block as a plain register, and both its read and its write latency are counted in clock cycles.

After power-on reset, the block first waits out the read latency and then copies the stored code into the counter. Nothing else happens until that copy is done. When adjust enable is high, step edges move the counter, and the counter stops at both ends of its range. The first step edge after enable rises is discarded, and so is the first step edge after a store finishes. A store begins only when the program flag has stayed high without a break for a qualifying number of cycles. Each request stores once, and the flag must fall before another store can be armed. Dropping adjust enable reloads the stored code, so any adjustment that was not saved is lost. The busy output is high during reloads and stores. Program-done pulses for one cycle when a write ends.

Top module: `trim_step_store`

## Requirements
- R1: Power-on reset holds busy_o high and trim_o at mid-scale (1 << (W-1), which is 64 for W=7). busy_o stays high for about RELOAD_CYC cycles after reset is released. It then falls, and trim_o shows the stored value, which is mid-scale when nothing has been stored yet.
- R2: With adjust enable high and busy_o low, each rising edge of up_i raises trim_o by one and each rising edge of down_i lowers it by one. One edge causes one step.
- R3: trim_o saturates. An up edge at 2^W-1 and a down edge at 0 leave it unchanged.
- R4: The first step edge seen after adjust enable rises is discarded.
- R5: With adjust enable low, step edges do not change trim_o and the program flag starts no store.
- R6: A fall of adjust enable drives busy_o high for about RELOAD_CYC cycles. trim_o keeps its old value during that time and then takes the stored value.
- R7: A store starts only after prog_i has been seen high, after synchronization, for QUAL_CYC consecutive cycles. A shorter assertion is discarded.
- R8: A store holds busy_o high for WRITE_CYC cycles, writes the current trim_o into the store, and pulses prog_done_o for exactly one cycle at the end. The stored value becomes visible at the next reload.
- R9: A single unbroken program request causes exactly one store. prog_i must fall before another store can be armed.
- R10: The first step edge seen after a store completes is discarded.
- R11: When up and down edges arrive in the same cycle, both are discarded and the counter is unchanged.
- R12: Step edges that arrive while busy_o is high do not change trim_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| en_i | input | 1 | Adjust enable level (asynchronous) |
| up_i | input | 1 | Up-step pulse (asynchronous) |
| down_i | input | 1 | Down-step pulse (asynchronous) |
| prog_i | input | 1 | Program-request level (asynchronous) |
| trim_o | output | W | Current trim code |
| busy_o | output | 1 | High during reload and store |
| prog_done_o | output | 1 | One-cycle pulse when a store write finishes |

## Verification
A wrong state register or a stuck discard-next-step flag shows up on trim_o at the next step edge: the code is off by one compared with the arithmetic model, and it stays off for every later step, so the bench compares trim_o after every pulse of a full up and down sweep. A timer or qualifier fault shows up on busy_o and prog_done_o. It appears either as a busy window of the wrong length after an enable fall, or as a store that fires on a short request, repeats on a long one, or never fires at all. A wrong stored value stays hidden until the next reload, so every store is followed by an enable fall and a comparison of the reloaded code.

// File: rtl/trim_pkg.sv
package trim_pkg;

    // Bit positions inside the synchronized input vector
    localparam int unsigned IN_UP   = 0;
    localparam int unsigned IN_DN   = 1;
    localparam int unsigned IN_PROG = 2;
    localparam int unsigned IN_EN   = 3;
    localparam int unsigned IN_NUM  = 4;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,  // waiting out the store read latency
        ST_LOCK  = 2'd1,  // adjust disabled, counter frozen
        ST_RUN   = 2'd2,  // adjust enabled, steps accepted
        ST_WRITE = 2'd3   // store write in progress
    } ctl_state_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_req_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Saturating single-step update; exactly one of up/dn is expected set
    function automatic int unsigned sat_step(input int unsigned cur, input int unsigned top,
                                             input step_req_t req);
        int unsigned nxt;
        nxt = cur;
        if (req.up && cur < top) nxt = cur + 1;
        if (req.dn && cur > 0)   nxt = cur - 1;
        return nxt;
    endfunction

endpackage

// File: rtl/trim_sync_edge.sv
module trim_sync_edge #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                    prev  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], din[gi]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign lvl[gi]  = chain[STAGES-1];
            assign rise[gi] = chain[STAGES-1] & ~prev;
        end
    endgenerate

endmodule

// File: rtl/trim_prog_qual.sv
module trim_prog_qual #(
    parameter int unsigned QUAL_CYC = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic allow,   // counting permitted in this state
    input  logic lvl,     // synchronized program level
    output logic fire     // one-cycle store start
);

    localparam int unsigned CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign fire = allow & lvl & armed & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (!lvl) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (fire) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (allow && armed) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/trim_nv_reg.sv
module trim_nv_reg #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);

    localparam logic [W-1:0] FACTORY = W'(1) << (W - 1);

    always_ff @(posedge clk) begin
        if (rst)     rdata <= FACTORY;
        else if (we) rdata <= wdata;
    end

endmodule

// File: rtl/trim_step_store.sv
module trim_step_store
    import trim_pkg::*;
#(
    parameter int unsigned W           = 7,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RELOAD_CYC  = 2000000,
    parameter int unsigned QUAL_CYC    = 40000,
    parameter int unsigned WRITE_CYC   = 20000000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         up_i,
    input  logic         down_i,
    input  logic         prog_i,
    output logic [W-1:0] trim_o,
    output logic         busy_o,
    output logic         prog_done_o
);

    localparam logic [W-1:0] MID     = W'(1) << (W - 1);
    localparam int unsigned  TOPV    = (1 << W) - 1;
    localparam int unsigned  TMAX    = max3(RELOAD_CYC, WRITE_CYC, 1);
    localparam int unsigned  TW      = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(RELOAD_CYC - 1);
    localparam logic [TW-1:0] T_WR   = TW'(WRITE_CYC - 1);

    logic [IN_NUM-1:0] in_lvl, in_rise;
    logic              en_s, prog_s;
    step_req_t         req;
    logic              fire;

    ctl_state_e        state;
    logic [TW-1:0]     timer;
    logic [W-1:0]      trim_q;
    logic              skip_q;
    logic              done_q;
    logic              wr_end;
    logic [W-1:0]      nv_q;

    trim_sync_edge #(.N(IN_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({en_i, prog_i, down_i, up_i}),
        .lvl  (in_lvl),
        .rise (in_rise)
    );

    assign en_s   = in_lvl[IN_EN];
    assign prog_s = in_lvl[IN_PROG];
    assign req.up = in_rise[IN_UP];
    assign req.dn = in_rise[IN_DN];

    trim_prog_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .allow (state == ST_RUN && en_s),
        .lvl   (prog_s),
        .fire  (fire)
    );

    assign wr_end = (state == ST_WRITE) && (timer == T_WR);

    trim_nv_reg #(.W(W)) u_nv (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_end),
        .wdata (trim_q),
        .rdata (nv_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_LOAD;
            timer  <= '0;
            trim_q <= MID;
            skip_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= wr_end;
            case (state)
                ST_LOAD: begin
                    if (timer == T_LOAD) begin
                        trim_q <= nv_q;
                        timer  <= '0;
                        state  <= ST_LOCK;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (en_s) begin
                        state  <= ST_RUN;
                        skip_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!en_s) begin
                        state <= ST_LOAD;
                        timer <= '0;
                    end else if (fire) begin
                        state <= ST_WRITE;
                        timer <= '0;
                    end else if (req.up ^ req.dn) begin
                        if (skip_q) skip_q <= 1'b0;
                        else        trim_q <= W'(sat_step(int'(trim_q), TOPV, req));
                    end
                end
                ST_WRITE: begin
                    if (wr_end) begin
                        state  <= ST_RUN;
                        timer  <= '0;
                        skip_q <= 1'b1;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    assign trim_o      = trim_q;
    assign busy_o      = (state == ST_LOAD) || (state == ST_WRITE);
    assign prog_done_o = done_q;

endmodule

// File: rtl/trim_step_store_chk.sv
module trim_step_store_chk #(
    parameter int unsigned W = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         en_lvl,
    input logic [W-1:0] trim_o,
    input logic         busy_o,
    input logic         prog_done_o
);

    // R2 / R3: outside busy windows the code moves by at most one per cycle
    p_step_unit_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o)) |->
            (trim_o == $past(trim_o) || trim_o == $past(trim_o) + 1'b1 ||
             trim_o == $past(trim_o) - 1'b1));

    // R5: enable low and idle means the code is frozen
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o) && $past(!en_lvl)) |-> $stable(trim_o));

    // R12: no change while busy continues
    p_busy_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(trim_o));

    // R8: done is a single-cycle pulse at the end of a busy window
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        prog_done_o |=> !prog_done_o);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        prog_done_o |-> ($past(busy_o) && !busy_o));

endmodule

bind trim_step_store trim_step_store_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_lvl      (en_s),
    .trim_o      (trim_o),
    .busy_o      (busy_o),
    .prog_done_o (prog_done_o)
);

// File: tb/sim_trim_step_store.sv
module sim_trim_step_store;

    localparam int W   = 7;
    localparam int RL  = 20;
    localparam int QL  = 16;
    localparam int WR  = 24;
    localparam int TOP = (1 << W) - 1;
    localparam int MID = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b0, up_i = 1'b0, down_i = 1'b0, prog_i = 1'b0;
    logic [W-1:0] trim_o;
    logic         busy_o, prog_done_o;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cyc = 0;
    int exp_v;

    always #2.5 clk = ~clk;

    trim_step_store #(.W(W), .SYNC_STAGES(2), .RELOAD_CYC(RL), .QUAL_CYC(QL),
                      .WRITE_CYC(WR)) u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .up_i(up_i), .down_i(down_i),
        .prog_i(prog_i), .trim_o(trim_o), .busy_o(busy_o), .prog_done_o(prog_done_o)
    );

    always @(negedge clk) begin
        if (!rst && prog_done_o) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 = up, 1 = down, 2 = both
    task automatic pulse(input int kind);
        @(negedge clk);
        up_i   = (kind != 1);
        down_i = (kind != 0);
        idle(3);
        up_i   = 1'b0;
        down_i = 1'b0;
        idle(4);
    endtask

    task automatic wait_not_busy(output int n);
        n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic model_step(input int kind, inout bit skip);
        if (kind == 2) return;
        if (skip) begin
            skip = 1'b0;
            return;
        end
        if (kind == 0 && exp_v < TOP) exp_v++;
        if (kind == 1 && exp_v > 0)   exp_v--;
    endtask

    initial begin : main
        int  n;
        int  d0;
        bit  skip;
        idle(5);
        chk(busy_o == 1'b1, "R1 busy in reset", int'(busy_o), 1);
        chk(int'(trim_o) == MID, "R1 mid in reset", int'(trim_o), MID);
        rst = 1'b0;
        wait_not_busy(n);
        chk(n >= RL - 2 && n <= RL + 2, "R1 load length", n, RL);
        chk(int'(trim_o) == MID, "R1 value after load", int'(trim_o), MID);
        exp_v = MID;

        // R5: steps with enable low
        pulse(0); pulse(0); pulse(1);
        chk(int'(trim_o) == MID, "R5 steps while disabled", int'(trim_o), MID);

        // R4: first step after enable is dropped
        en_i = 1'b1;
        idle(4);
        skip = 1'b1;
        pulse(0); model_step(0, skip);
        chk(int'(trim_o) == MID, "R4 first step dropped", int'(trim_o), MID);
        pulse(0); model_step(0, skip);
        chk(int'(trim_o) == MID + 1, "R2 up step", int'(trim_o), MID + 1);
        pulse(1); model_step(1, skip);
        pulse(1); model_step(1, skip);
        chk(int'(trim_o) == MID - 1, "R2 two down steps", int'(trim_o), MID - 1);

        // R11: coincident edges
        pulse(2); model_step(2, skip);
        chk(int'(trim_o) == exp_v, "R11 both edges ignored", int'(trim_o), exp_v);

        // R3: sweep to the top, then to the bottom
        for (int i = 0; i < TOP - MID + 8; i++) begin
            pulse(0); model_step(0, skip);
            chk(int'(trim_o) == exp_v, "R3 up sweep", int'(trim_o), exp_v);
        end
        chk(int'(trim_o) == TOP, "R3 top saturation", int'(trim_o), TOP);
        for (int i = 0; i < TOP + 8; i++) begin
            pulse(1); model_step(1, skip);
            chk(int'(trim_o) == exp_v, "R3 down sweep", int'(trim_o), exp_v);
        end
        chk(int'(trim_o) == 0, "R3 bottom saturation", int'(trim_o), 0);
        for (int i = 0; i < 5; i++) begin
            pulse(0); model_step(0, skip);
        end
        chk(int'(trim_o) == 5, "R2 five up steps", int'(trim_o), 5);

        // R7: short request discarded
        d0 = done_cnt;
        @(negedge clk); prog_i = 1'b1;
        idle(QL / 2);
        prog_i = 1'b0;
        idle(WR + 10);
        chk(done_cnt == d0, "R7 short request discarded", done_cnt - d0, 0);
        chk(busy_o == 1'b0, "R7 no busy after short request", int'(busy_o), 0);

        // R7/R8/R12/R9: held request stores once, steps during write dropped
        @(negedge clk); prog_i = 1'b1;
        n = 0;
        while (!busy_o && n < 200) begin @(negedge clk); n++; end
        chk(n >= QL && n <= QL + 4, "R7 qualify time", n, QL + 2);
        pulse(0);
        chk(busy_o == 1'b1, "R8 busy during write", int'(busy_o), 1);
        chk(int'(trim_o) == 5, "R12 step during write dropped", int'(trim_o), 5);
        wait_not_busy(n);
        idle(2);
        chk(done_cnt == d0 + 1, "R8 one done pulse", done_cnt - d0, 1);
        idle(3 * (QL + WR));
        chk(done_cnt == d0 + 1, "R9 held request stores once", done_cnt - d0, 1);
        prog_i = 1'b0;
        idle(4);

        // R10: first step after store dropped
        skip = 1'b1;
        pulse(0); model_step(0, skip);
        chk(int'(trim_o) == 5, "R10 first step after store dropped", int'(trim_o), 5);
        pulse(0); model_step(0, skip);
        chk(int'(trim_o) == 6, "R10 next step applied", int'(trim_o), 6);

        // R6/R8: enable fall reloads the stored 5
        @(negedge clk); en_i = 1'b0;
        idle(6);
        chk(busy_o == 1'b1, "R6 busy during reload", int'(busy_o), 1);
        chk(int'(trim_o) == 6, "R6 old value held during reload", int'(trim_o), 6);
        wait_not_busy(n);
        chk(n >= RL - 8 && n <= RL, "R6 reload length", n + 6, RL + 3);
        chk(int'(trim_o) == 5, "R8 stored value reloaded", int'(trim_o), 5);
        exp_v = 5;

        // R5: no store while disabled
        d0 = done_cnt;
        @(negedge clk); prog_i = 1'b1;
        idle(3 * QL);
        prog_i = 1'b0;
        idle(WR + 4);
        chk(done_cnt == d0, "R5 no store while disabled", done_cnt - d0, 0);
        chk(busy_o == 1'b0, "R5 idle while disabled", int'(busy_o), 0);

        // second store of a new value, verified through reload
        en_i = 1'b1;
        idle(4);
        skip = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pulse(1); model_step(1, skip);
        end
        chk(int'(trim_o) == exp_v, "R4 skip after re-enable", int'(trim_o), exp_v);
        @(negedge clk); prog_i = 1'b1;
        idle(QL + 6);
        prog_i = 1'b0;
        wait_not_busy(n);
        idle(2);
        chk(done_cnt == d0 + 1, "R9 released request stores", done_cnt - d0, 1);
        pulse(0);
        chk(int'(trim_o) == exp_v, "R10 skip after second store", int'(trim_o), exp_v);
        @(negedge clk); en_i = 1'b0;
        idle(4);
        wait_not_busy(n);
        chk(int'(trim_o) == exp_v, "R8 second stored value", int'(trim_o), exp_v);

        finish_run();
    end

endmodule